// File: doc/BRIEF.md
# Baud-Framed Control Word Serializer

This block sits on the signal-processor side of a line transceiver and sends a 16-bit control word to an analog front end over one serial data line. A free-running oversampling clock at 48 times the symbol rate drives it. The block divides that clock into frames of 48 bit slots and raises a baud strobe for one cycle at the start of each frame. Raising the symbol rate or lowering it only changes the clock frequency: 32 k to 584 k symbols per second means a clock of 1.536 MHz to 28.032 MHz.

Upstream logic presents the control fields on a parallel port and pulses a load strobe. The fields go into a staging register. At the last slot of every frame the staging contents are packed into a 16-bit word and copied to a holding register. The holding register is then shifted out MSB first during the first 16 slots of the next frame, and the line stays low for the rest of that frame. The line is updated on the falling clock edge, so it is stable when the receiver samples on the rising edge. When the transmit-enable field is clear, the symbol field is replaced by the zero-symbol code. The baud strobe tells upstream logic when to supply the next symbol.

Top module: `baud_ctl_serializer`

## Requirements
- R1: A frame is exactly 48 clock cycles. `baud_stb` is high for exactly one cycle, in slot 1 of every frame, and is low in the other 47 slots.
- R2: In slot k (1 to 16) the line carries word bit 16-k, so the word goes out MSB first. The word layout is: bit 15 transmit enable, bits 14:13 symbol code, bits 12:10 receive gain, bit 9 loopback.
- R3: Word bits 8 down to 0 are reserved and are always sent as 0. These are slots 8 to 16.
- R4: The line is low during slots 17 to 48 of every frame.
- R5: When the transmit-enable field is 0, the symbol code is sent as 00 (the zero symbol), whatever value `ctl_sym` holds.
- R6: When the transmit-enable field is 1, all four symbol codes 00, 01, 10 and 11 are sent unchanged in bits 14:13.
- R7: A load during a frame does not change the rest of that frame. The new fields first appear in the frame that follows.
- R8: While reset is asserted, `ser_data` and `baud_stb` are low. The first frame after reset carries an all-zero word.
- R9: `ser_data` changes only on the falling clock edge. The value seen just after a falling edge is still present just after the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk48 | input | 1 | Continuous clock at 48 times the symbol rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctl_load | input | 1 | One-cycle strobe that captures the control fields |
| ctl_tx_en | input | 1 | Transmit enable field |
| ctl_sym | input | 2 | Symbol code, one of four line levels |
| ctl_gain | input | 3 | Receive gain code |
| ctl_lpbk | input | 1 | Loopback field |
| ser_data | output | 1 | Serial control word line, updated on the falling edge |
| baud_stb | output | 1 | One-cycle frame start strobe |

## Verification
`baud_stb` goes high in the cycle that follows the wrap of the slot counter. The bench therefore syncs to the strobe and then counts slots itself, checking the strobe 5 ns after each rising edge. The bit for slot k appears after the falling edge inside slot k. The bench samples it 15 ns after the rising edge that starts the slot. To cover R9, it samples the same value again 5 ns after the next rising edge. A load issued in slot 3 passes through two registers: the staging register at the end of slot 3, and the holding register at the end of slot 48. The bench therefore expects the new word one frame boundary later and the old word for the rest of the current frame.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int SYM_W   = 2;
  localparam int GAIN_W  = 3;
  localparam int FIELD_W = 1 + SYM_W + GAIN_W + 1;

  typedef struct packed {
    logic              tx_en;
    logic [SYM_W-1:0]  sym;
    logic [GAIN_W-1:0] gain;
    logic              lpbk;
  } ctl_fields_t;

  localparam logic [SYM_W-1:0] SYM_ZERO = '0;
endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/bsr_slot_ctr.sv
module bsr_slot_ctr #(
  parameter int FRAME_SLOTS = 48,
  localparam int SLOT_W = $clog2(FRAME_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_o,
  output logic              frame_start_o,
  output logic              frame_end_o
);
  localparam logic [SLOT_W-1:0] LAST  = SLOT_W'(FRAME_SLOTS);
  localparam logic [SLOT_W-1:0] FIRST = SLOT_W'(1);

  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    if (slot_q == LAST) slot_d = FIRST;
    else                slot_d = slot_q + FIRST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= LAST;
    else        slot_q <= slot_d;
  end

  assign slot_o        = slot_q;
  assign frame_start_o = (slot_q == FIRST);
  assign frame_end_o   = (slot_q == LAST);

  a_r1_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q >= FIRST) && (slot_q <= LAST));
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == LAST) |=> (slot_q == FIRST));
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q != LAST) |=> (slot_q == $past(slot_q) + FIRST));
endmodule

// File: rtl/bsr_word_reg.sv
module bsr_word_reg
  import bsr_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int RSV_W = WORD_W - FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  ctl_fields_t       fields_i,
  input  logic              frame_end_i,
  output logic [WORD_W-1:0] word_o
);
  ctl_fields_t       stage_q, stage_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic [FIELD_W-1:0] eff_fields;
  logic [WORD_W-1:0] packed_word;

  // Disabled transmitter: symbol code collapses to the zero symbol.
  always_comb begin
    eff_fields = {stage_q.tx_en,
                  stage_q.tx_en ? stage_q.sym : SYM_ZERO,
                  stage_q.gain,
                  stage_q.lpbk};
  end

  generate
    if (RSV_W > 0) begin : g_rsv
      assign packed_word = {eff_fields, {RSV_W{1'b0}}};
    end else begin : g_norsv
      assign packed_word = eff_fields[FIELD_W-1 -: WORD_W];
    end
  endgenerate

  always_comb begin
    stage_d = stage_q;
    if (load_i) stage_d = fields_i;
  end

  always_comb begin
    hold_d = hold_q;
    if (frame_end_i) hold_d = packed_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      hold_q  <= '0;
    end else begin
      stage_q <= stage_d;
      hold_q  <= hold_d;
    end
  end

  assign word_o = hold_q;

  // R7: the held word only moves at the frame boundary
  a_r7_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_i |=> $stable(word_o));
endmodule

// File: rtl/bsr_shifter.sv
module bsr_shifter
  import bsr_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int FRAME_SLOTS = 48,
  localparam int SLOT_W = $clog2(FRAME_SLOTS + 1),
  localparam int IDX_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ser_o
);
  localparam logic [SLOT_W-1:0] WORD_SLOTS = SLOT_W'(WORD_W);
  localparam logic [SLOT_W-1:0] FLD_SLOTS  = SLOT_W'(FIELD_W);
  localparam logic [SLOT_W-1:0] SYM_FIRST  = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] SYM_LAST   = SLOT_W'(1 + SYM_W);

  logic [SLOT_W-1:0] idx_full;
  logic              in_word;
  logic              ser_q, ser_d;

  always_comb begin
    in_word  = (slot_i <= WORD_SLOTS);
    idx_full = WORD_SLOTS - slot_i;
    ser_d    = in_word ? word_i[idx_full[IDX_W-1:0]] : 1'b0;
  end

  // Launch on the falling edge so the line is settled at the rising edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ser_q <= 1'b0;
    else        ser_q <= ser_d;
  end

  assign ser_o = ser_q;

  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i > WORD_SLOTS) |-> !ser_q);
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i > FLD_SLOTS) && (slot_i <= WORD_SLOTS) |-> !ser_q);
  a_r5_disabled_zero_sym: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i >= SYM_FIRST) && (slot_i <= SYM_LAST) && !word_i[WORD_W-1] |-> !ser_q);
endmodule

// File: rtl/baud_ctl_serializer.sv
module baud_ctl_serializer
  import bsr_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int FRAME_SLOTS = 48,
  localparam int SLOT_W = $clog2(FRAME_SLOTS + 1)
) (
  input  logic              clk48,
  input  logic              rst_n,
  input  logic              ctl_load,
  input  logic              ctl_tx_en,
  input  logic [SYM_W-1:0]  ctl_sym,
  input  logic [GAIN_W-1:0] ctl_gain,
  input  logic              ctl_lpbk,
  output logic              ser_data,
  output logic              baud_stb
);
  logic              srst_n;
  logic [SLOT_W-1:0] slot;
  logic              frame_start, frame_end;
  logic [WORD_W-1:0] frame_word;
  ctl_fields_t       fields;

  always_comb begin
    fields.tx_en = ctl_tx_en;
    fields.sym   = ctl_sym;
    fields.gain  = ctl_gain;
    fields.lpbk  = ctl_lpbk;
  end

  bsr_rst_sync u_rst (
    .clk    (clk48),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  bsr_slot_ctr #(.FRAME_SLOTS(FRAME_SLOTS)) u_slot (
    .clk           (clk48),
    .rst_n         (srst_n),
    .slot_o        (slot),
    .frame_start_o (frame_start),
    .frame_end_o   (frame_end)
  );

  bsr_word_reg #(.WORD_W(WORD_W)) u_word (
    .clk         (clk48),
    .rst_n       (srst_n),
    .load_i      (ctl_load),
    .fields_i    (fields),
    .frame_end_i (frame_end),
    .word_o      (frame_word)
  );

  bsr_shifter #(.WORD_W(WORD_W), .FRAME_SLOTS(FRAME_SLOTS)) u_shift (
    .clk    (clk48),
    .rst_n  (srst_n),
    .slot_i (slot),
    .word_i (frame_word),
    .ser_o  (ser_data)
  );

  assign baud_stb = frame_start;

  // R1: the strobe never lasts beyond one cycle
  a_r1_stb_single: assert property (@(posedge clk48) disable iff (!srst_n)
    baud_stb |=> !baud_stb);
  // R1: the strobe follows the last slot of the previous frame
  a_r1_stb_after_end: assert property (@(posedge clk48) disable iff (!srst_n)
    frame_end |=> baud_stb);
endmodule

// File: tb/sim_baud_ctl_serializer.sv
`timescale 1ns/1ps
module sim_baud_ctl_serializer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_load, ctl_tx_en, ctl_lpbk;
  logic [1:0] ctl_sym;
  logic [2:0] ctl_gain;
  logic       sd, stb;
  int         nvec = 0;
  int         nfail = 0;

  always #10 clk = ~clk;

  baud_ctl_serializer u0 (
    .clk48     (clk),
    .rst_n     (rst_n),
    .ctl_load  (ctl_load),
    .ctl_tx_en (ctl_tx_en),
    .ctl_sym   (ctl_sym),
    .ctl_gain  (ctl_gain),
    .ctl_lpbk  (ctl_lpbk),
    .ser_data  (sd),
    .baud_stb  (stb)
  );

  task automatic chk(input logic act, input logic exp, input string req, input int slot);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s slot %0d: actual %b expected %b", req, slot, act, exp);
    end
  endtask

  // Word layout (R2, R3): {en, en ? sym : 00, gain, lpbk, 9'b0}; R5 zeroes sym when en=0
  function automatic logic [15:0] exp_word(input logic [6:0] v);
    logic en = v[6];
    return {en, (en ? v[5:4] : 2'b00), v[3:1], v[0], 9'b0};
  endfunction

  // Entered at rising edge + 5 ns of slot 1; returns at rising edge + 5 ns of the next slot 1.
  task automatic run_frame(input logic [15:0] expw, input logic ld, input logic [6:0] nv,
                           input logic after_ld);
    logic prev = 1'b0;
    for (int s = 1; s <= 48; s++) begin
      logic  eb;
      string tag;
      if (s > 1) begin
        @(posedge clk); #5;
      end
      chk(stb, (s == 1), "R1 baud strobe", s);
      chk(sd, prev, "R9 held across rising edge", s);
      if (ld && s == 3) begin
        ctl_tx_en = nv[6]; ctl_sym = nv[5:4]; ctl_gain = nv[3:1]; ctl_lpbk = nv[0];
        ctl_load  = 1'b1;
      end
      if (s == 4) ctl_load = 1'b0;
      #10;
      eb = (s <= 16) ? expw[16-s] : 1'b0;
      if (s >= 17)               tag = "R4 idle low";
      else if (s >= 8)           tag = "R3 reserved";
      else if (s == 2 || s == 3) tag = expw[15] ? "R6 symbol" : "R5 zero symbol";
      else if (ld && s >= 4)     tag = "R7 mid-frame load";
      else                       tag = "R2 field bit";
      if (after_ld && s == 1) tag = "R7 new word";
      chk(sd, eb, tag, s);
      prev = eb;
    end
    @(posedge clk); #5;
  endtask

  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int guard = 0;
    rst_n = 1'b0; ctl_load = 1'b0; ctl_tx_en = 1'b0; ctl_sym = 2'b00;
    ctl_gain = 3'b000; ctl_lpbk = 1'b0;
    repeat (4) @(posedge clk);
    #5;
    chk(sd,  1'b0, "R8 reset line", 0);
    chk(stb, 1'b0, "R8 reset strobe", 0);
    // a load during reset must not survive it
    ctl_tx_en = 1'b1; ctl_sym = 2'b11; ctl_gain = 3'b111; ctl_lpbk = 1'b1; ctl_load = 1'b1;
    @(posedge clk); #5;
    chk(sd, 1'b0, "R8 reset line", 0);
    ctl_load = 1'b0; ctl_tx_en = 1'b0; ctl_sym = 2'b00; ctl_gain = 3'b000; ctl_lpbk = 1'b0;
    rst_n = 1'b1;
    do begin
      @(posedge clk); #5;
      guard++;
    end while (!stb && guard < 60);
    chk(stb, 1'b1, "R1 first strobe", 1);
    // R8: first frame after reset is all zeros; vector 0 is loaded in slot 3
    run_frame(16'h0000, 1'b1, 7'd0, 1'b0);
    for (int v = 0; v < 128; v++) begin
      run_frame(exp_word(7'(v)), (v < 127), 7'(v + 1), 1'b1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule